// File: doc/BRIEF.md
# Mutual-Clocking Keystream Generator

This block produces a binary keystream from an 80-bit secret key and an initialisation vector of 0 to 80 bits. It holds two 80-bit registers. One register steps as a linear feedback register. The other steps through a fixed nonlinear per-stage update. Each register chooses between two stepping modes using a control bit, and that control bit mixes one tap from each register. After a start pulse, the block clears both registers. It then absorbs the IV bits, then the key bits, then runs 80 idle steps. From then on it offers one keystream bit per step.

The keystream leaves on a single-bit valid/ready stream. While `ks_valid` is high, `ks_bit` is the current output bit. The registers advance only in a cycle where `ks_valid` and `ks_ready` are both high. When `ks_ready` is low, the offered bit and the state are held unchanged, so the consumer may stall for any number of cycles. The block counts the bits it has handed out and stops offering bits once the usage limit is reached. `busy` is a plain status flag that stays high for the whole load sequence.

`key` and `iv` are read bit by bit while loading, so they must be held stable while `busy` is high. `iv_len` is captured when a start is accepted.

Top module: `keystream_gen`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `ks_valid` are low until a start is accepted.
- R2: A start pulse seen while `busy` is low is accepted. It clears both registers, and `busy` is high from the next cycle for exactly L + 160 cycles, where L is the effective IV length.
- R3: An `iv_len` value above 80 behaves exactly like 80, in load time and in keystream.
- R4: A start pulse while `busy` is high has no effect. Load time and keystream are those of the load already in progress.
- R5: The linear register's jump bit is s27 XOR r53. The nonlinear register's table select is s53 XOR r26. Stage 0 is the shift-in end of each register.
- R6: The load steps feed `iv[0]` up to `iv[L-1]`, then `key[0]` up to `key[79]`, then 80 zeros. During these steps the linear register's input is the step bit XOR s40. Keystream steps feed 0 with no s40 term.
- R7: `ks_bit` is r0 XOR s0 of the current state. The state advances by one keystream step per accepted transfer. The output matches a bit-exact model for IV lengths 0, 1, 37 and 80.
- R8: After 2^LIMIT_LOG accepted bits, `ks_valid` stays low until the next accepted start.
- R9: While `ks_valid` is high and `ks_ready` is low, `ks_valid` stays high and `ks_bit` keeps its value in the next cycle.
- R10: A start accepted while keystream is being produced restarts the load with the new key and IV.
- R11: `ks_valid` is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new load; ignored while busy |
| key | input | KEY_W (80) | Secret key; bit i is fed at load step i |
| iv | input | IV_MAX (80) | Initialisation vector; bit 0 fed first |
| iv_len | input | 7 | Number of IV bits to use; values above 80 act as 80 |
| busy | output | 1 | High during the load sequence |
| ks_valid | output | 1 | Keystream bit available |
| ks_ready | input | 1 | Consumer accepts the offered bit |
| ks_bit | output | 1 | Current keystream bit |

## Verification
A wrong stage or tap in either register spreads into r0 XOR s0 within a few steps. The nonlinear update mixes neighbouring stages on every step, so a mismatch appears in the first 32 keystream bits compared against the model for each key/IV pair. A mistake in the load sequencer shows at once at the ports: `busy` stays high for a different number of cycles than L + 160, or the keystream from a clamped or interrupted load departs from its reference. Faults in stalling or in the usage counter show as a changed bit or a lost `ks_valid` during back-pressure, or as `ks_valid` still high after the limit.

// File: rtl/mkg_pkg.sv
package mkg_pkg;
  localparam int NREG = 80;

  // taps combined into the per-register control bits
  localparam int JMP_TAP_S = 27;
  localparam int JMP_TAP_R = 53;
  localparam int SEL_TAP_S = 53;
  localparam int SEL_TAP_R = 26;
  // nonlinear-register stage folded into the linear input while loading
  localparam int MIX_TAP_S = 40;

  // feedback positions of the linear register, index 0 leftmost
  localparam logic [0:NREG-1] LIN_TAPS =
    80'b1010101111_0001101100_1010101110_0000110101_0101000001_0110101000_0010000101_0101001011;
  // per-stage complement masks of the nonlinear AND term
  localparam logic [0:NREG-1] NL_AND_A =
    80'b0_00011000101111010010101010_101101001000000010101010000_1010011110010101111111110_0;
  localparam logic [0:NREG-1] NL_AND_B =
    80'b0_10110010111100101000110101_110111100011010111000010001_0111000111111010111011110_0;
  // feedback masks of the nonlinear register, chosen by the select bit
  localparam logic [0:NREG-1] NL_FB_LO =
    80'b111101011111111001011111111_110011000000111001001010100_10111101010100000000011010;
  localparam logic [0:NREG-1] NL_FB_HI =
    80'b111011100001110100110001001_100101100011000001101100010_00100100101101010010100011;

  typedef enum logic [2:0] {ST_IDLE, ST_IV, ST_KEY, ST_PRE, ST_RUN} seq_state_e;
  typedef enum logic [1:0] {SRC_ZERO, SRC_IV, SRC_KEY} step_src_e;
endpackage

// File: rtl/mkg_lin_next.sv
module mkg_lin_next
  import mkg_pkg::*;
(
  input  logic [NREG-1:0] cur,
  input  logic            in_bit,
  input  logic            jump,
  output logic [NREG-1:0] nxt
);
  logic fb;
  assign fb = cur[NREG-1] ^ in_bit;

  for (genvar i = 0; i < NREG; i++) begin : g_stage
    logic shifted;
    if (i == 0) begin : g_head
      assign shifted = 1'b0;
    end else begin : g_body
      assign shifted = cur[i-1];
    end
    // jump mode adds the old stage value back in (multiply by x+1)
    assign nxt[i] = shifted ^ (LIN_TAPS[i] & fb) ^ (jump & cur[i]);
  end
endmodule

// File: rtl/mkg_nl_next.sv
module mkg_nl_next
  import mkg_pkg::*;
(
  input  logic [NREG-1:0] cur,
  input  logic            in_bit,
  input  logic            sel_hi,
  output logic [NREG-1:0] nxt
);
  logic fb;
  assign fb = cur[NREG-1] ^ in_bit;

  for (genvar i = 0; i < NREG; i++) begin : g_stage
    logic hat;
    if (i == 0) begin : g_head
      assign hat = 1'b0;
    end else if (i == NREG-1) begin : g_tail
      assign hat = cur[NREG-2];
    end else begin : g_body
      assign hat = cur[i-1] ^ ((cur[i] ^ NL_AND_A[i]) & (cur[i+1] ^ NL_AND_B[i]));
    end
    assign nxt[i] = hat ^ ((sel_hi ? NL_FB_HI[i] : NL_FB_LO[i]) & fb);
  end
endmodule

// File: rtl/mkg_seq.sv
module mkg_seq
  import mkg_pkg::*;
#(
  parameter int KEY_W     = 80,
  parameter int IV_MAX    = 80,
  parameter int LIMIT_LOG = 40,
  parameter int LEN_W     = 7,
  parameter int CNT_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] iv_len,
  input  logic             ks_ready,
  output logic             busy,
  output logic             clear,
  output logic             step,
  output logic             mix,
  output logic             ks_valid,
  output step_src_e        src,
  output logic [CNT_W-1:0] idx
);
  seq_state_e       state;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] eff_len;
  logic [LIMIT_LOG:0] used;
  logic             start_ok;

  assign busy     = (state == ST_IV) || (state == ST_KEY) || (state == ST_PRE);
  assign start_ok = start && !busy;
  assign clear    = start_ok;
  assign eff_len  = (int'(iv_len) > IV_MAX) ? LEN_W'(IV_MAX) : iv_len;
  assign ks_valid = (state == ST_RUN) && !used[LIMIT_LOG];
  assign step     = busy || (ks_valid && ks_ready);
  assign mix      = busy;

  always_comb begin
    unique case (state)
      ST_IV:   src = SRC_IV;
      ST_KEY:  src = SRC_KEY;
      default: src = SRC_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      len_q <= '0;
      used  <= '0;
    end else if (start_ok) begin
      state <= (eff_len == '0) ? ST_KEY : ST_IV;
      idx   <= '0;
      len_q <= eff_len;
      used  <= '0;
    end else begin
      unique case (state)
        ST_IV: begin
          if (int'(idx) == int'(len_q) - 1) begin
            state <= ST_KEY;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_KEY: begin
          if (int'(idx) == KEY_W - 1) begin
            state <= ST_PRE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_PRE: begin
          if (int'(idx) == NREG - 1) begin
            state <= ST_RUN;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_RUN: begin
          if (ks_valid && ks_ready) used <= used + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/keystream_gen.sv
module keystream_gen
  import mkg_pkg::*;
#(
  parameter int KEY_W     = 80,
  parameter int IV_MAX    = 80,
  parameter int LIMIT_LOG = 40,
  localparam int LEN_W    = $clog2(IV_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [KEY_W-1:0]  key,
  input  logic [IV_MAX-1:0] iv,
  input  logic [LEN_W-1:0]  iv_len,
  output logic              busy,
  output logic              ks_valid,
  input  logic              ks_ready,
  output logic              ks_bit
);
  localparam int MAX_A = (KEY_W > IV_MAX) ? KEY_W : IV_MAX;
  localparam int MAX_N = (MAX_A > NREG) ? MAX_A : NREG;
  localparam int CNT_W = $clog2(MAX_N);

  logic [NREG-1:0]  r_q, s_q, r_nx, s_nx;
  logic             clear, step, mix, in_bit, lin_in, jump_r, sel_s;
  step_src_e        src;
  logic [CNT_W-1:0] idx;

  mkg_seq #(
    .KEY_W(KEY_W), .IV_MAX(IV_MAX), .LIMIT_LOG(LIMIT_LOG),
    .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .iv_len(iv_len),
    .ks_ready(ks_ready), .busy(busy), .clear(clear), .step(step),
    .mix(mix), .ks_valid(ks_valid), .src(src), .idx(idx)
  );

  always_comb begin
    unique case (src)
      SRC_IV:  in_bit = iv[idx];
      SRC_KEY: in_bit = key[idx];
      default: in_bit = 1'b0;
    endcase
  end

  // each control bit draws on both registers
  assign jump_r = s_q[JMP_TAP_S] ^ r_q[JMP_TAP_R];
  assign sel_s  = s_q[SEL_TAP_S] ^ r_q[SEL_TAP_R];
  assign lin_in = in_bit ^ (mix & s_q[MIX_TAP_S]);

  mkg_lin_next u_lin (.cur(r_q), .in_bit(lin_in), .jump(jump_r), .nxt(r_nx));
  mkg_nl_next  u_nl  (.cur(s_q), .in_bit(in_bit), .sel_hi(sel_s), .nxt(s_nx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= '0;
      s_q <= '0;
    end else if (clear) begin
      r_q <= '0;
      s_q <= '0;
    end else if (step) begin
      r_q <= r_nx;
      s_q <= s_nx;
    end
  end

  assign ks_bit = r_q[0] ^ s_q[0];
endmodule

// File: rtl/keystream_gen_chk.sv
module keystream_gen_chk
  import mkg_pkg::*;
#(
  parameter int KEY_W     = 80,
  parameter int IV_MAX    = 80,
  parameter int LIMIT_LOG = 40,
  parameter int LEN_W     = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] iv_len,
  input logic             busy,
  input logic             ks_valid,
  input logic             ks_ready,
  input logic             ks_bit
);
  localparam logic [LIMIT_LOG:0] LIM = {1'b1, {LIMIT_LOG{1'b0}}};

  int                 busy_cnt;
  int                 busy_exp;
  logic [LIMIT_LOG:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= 0;
      busy_exp <= 0;
      acc      <= '0;
    end else if (start && !busy) begin
      busy_cnt <= 0;
      busy_exp <= ((int'(iv_len) > IV_MAX) ? IV_MAX : int'(iv_len)) + KEY_W + NREG;
      acc      <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt + 1;
      if (ks_valid && ks_ready) acc <= acc + 1'b1;
    end
  end

  // R11
  busy_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ks_valid);
  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  // R2
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == busy_exp) && ks_valid);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid && !ks_ready && !start |=> ks_valid && $stable(ks_bit));
  // R8
  usage_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid |-> acc < LIM);
endmodule

bind keystream_gen keystream_gen_chk #(
  .KEY_W(KEY_W), .IV_MAX(IV_MAX), .LIMIT_LOG(LIMIT_LOG), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .iv_len(iv_len), .busy(busy),
  .ks_valid(ks_valid), .ks_ready(ks_ready), .ks_bit(ks_bit)
);

// File: tb/tb_keystream_gen.sv
`timescale 1ns/1ps
module tb_keystream_gen;
  localparam int LIM_LOG = 6;

  logic        clk = 1'b0;
  logic        rst_n, start, ks_ready;
  logic [79:0] key, iv;
  logic [6:0]  iv_len;
  logic        busy, ks_valid, ks_bit;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  keystream_gen #(.KEY_W(80), .IV_MAX(80), .LIMIT_LOG(LIM_LOG)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .iv(iv),
    .iv_len(iv_len), .busy(busy), .ks_valid(ks_valid),
    .ks_ready(ks_ready), .ks_bit(ks_bit)
  );

  // reference constants, index 0 leftmost
  localparam logic [0:79] M_TAP =
    80'b1010101111_0001101100_1010101110_0000110101_0101000001_0110101000_0010000101_0101001011;
  localparam logic [0:79] M_CA =
    80'b0_00011000101111010010101010_101101001000000010101010000_1010011110010101111111110_0;
  localparam logic [0:79] M_CB =
    80'b0_10110010111100101000110101_110111100011010111000010001_0111000111111010111011110_0;
  localparam logic [0:79] M_F0 =
    80'b111101011111111001011111111_110011000000111001001010100_10111101010100000000011010;
  localparam logic [0:79] M_F1 =
    80'b111011100001110100110001001_100101100011000001101100010_00100100101101010010100011;

  // stimulus table
  localparam logic [79:0] TV_KEY [4] = '{80'h0123456789ABCDEF0123, 80'hFFFFFFFFFFFFFFFFFFFF,
                                         80'h00000000000000000001, 80'hC3A55A3C9E1F0B7D2468};
  localparam logic [79:0] TV_IV  [4] = '{80'h0, 80'hFEDCBA9876543210ABCD,
                                         80'h00000000001234567890, 80'h1};
  localparam logic [6:0]  TV_LEN [4] = '{7'd0, 7'd80, 7'd37, 7'd1};
  localparam int          TV_MODE[4] = '{0, 1, 0, 1};

  // state layout {r, s}
  function automatic logic [159:0] ref_step(input logic [159:0] st, input logic mx, input logic b);
    logic [79:0] r, s, rn, sn, h;
    logic cr, cs, fr, fs;
    r = st[159:80];
    s = st[79:0];
    cr = s[27] ^ r[53];
    cs = s[53] ^ r[26];
    fr = r[79] ^ b ^ (mx & s[40]);
    fs = s[79] ^ b;
    for (int i = 0; i < 80; i++) begin
      rn[i] = (M_TAP[i] & fr) ^ (cr & r[i]);
      if (i > 0) rn[i] = rn[i] ^ r[i-1];
    end
    h[0] = 1'b0;
    h[79] = s[78];
    for (int i = 1; i < 79; i++)
      h[i] = s[i-1] ^ ((s[i] ^ M_CA[i]) & (s[i+1] ^ M_CB[i]));
    for (int i = 0; i < 80; i++)
      sn[i] = h[i] ^ ((cs ? M_F1[i] : M_F0[i]) & fs);
    return {rn, sn};
  endfunction

  function automatic logic [63:0] ref_ks(input logic [79:0] k, input logic [79:0] v,
                                         input int len, input int n);
    logic [159:0] st;
    logic [63:0]  z;
    int L;
    st = '0;
    z = '0;
    L = (len > 80) ? 80 : len;
    for (int i = 0; i < L; i++)  st = ref_step(st, 1'b1, v[i]);
    for (int i = 0; i < 80; i++) st = ref_step(st, 1'b1, k[i]);
    for (int i = 0; i < 80; i++) st = ref_step(st, 1'b1, 1'b0);
    for (int i = 0; i < n; i++) begin
      z[i] = st[80] ^ st[0];
      st = ref_step(st, 1'b0, 1'b0);
    end
    return z;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_load(input logic [79:0] k, input logic [79:0] v, input logic [6:0] len,
                          output int cyc, output bit saw_valid);
    @(negedge clk);
    key = k; iv = v; iv_len = len; start = 1'b1; ks_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    saw_valid = 1'b0;
    while (busy && cyc < 2000) begin
      if (ks_valid) saw_valid = 1'b1;
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic consume(input int n, input int mode, output logic [63:0] got);
    int j, c;
    got = '0;
    j = 0;
    c = 0;
    while (j < n && c < 1000) begin
      ks_ready = (mode == 0) ? 1'b1 : ((c % 3) != 2);
      if (ks_valid && ks_ready) begin
        got[j] = ks_bit;
        j++;
      end
      c++;
      @(negedge clk);
    end
    ks_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    bit sv, bad;
    logic [63:0] got, exp;
    logic b0;
    rst_n = 1'b0; start = 1'b0; ks_ready = 1'b0; key = '0; iv = '0; iv_len = '0;
    repeat (3) @(negedge clk);
    check(!busy && !ks_valid, "R1 in reset", {62'd0, busy, ks_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !ks_valid, "R1 after reset", {62'd0, busy, ks_valid}, 64'd0);

    // table walk; entries after the first restart from the running state (R10)
    for (int t = 0; t < 4; t++) begin
      run_load(TV_KEY[t], TV_IV[t], TV_LEN[t], cyc, sv);
      check(cyc == int'(TV_LEN[t]) + 160, "R2 load length", 64'(cyc), 64'(int'(TV_LEN[t]) + 160));
      check(!sv, "R11 no valid while busy", 64'(sv), 64'd0);
      consume(32, TV_MODE[t], got);
      exp = ref_ks(TV_KEY[t], TV_IV[t], int'(TV_LEN[t]), 32);
      check(got == exp, (t == 0) ? "R5 R6 R7 keystream" : "R7 R10 keystream after restart", got, exp);
    end

    // R3: oversize length acts as 80
    run_load(TV_KEY[1], TV_IV[1], 7'd100, cyc, sv);
    check(cyc == 240, "R3 clamped load length", 64'(cyc), 64'd240);
    consume(32, 0, got);
    exp = ref_ks(TV_KEY[1], TV_IV[1], 80, 32);
    check(got == exp, "R3 clamped keystream", got, exp);

    // R4: start during load is ignored
    @(negedge clk);
    key = TV_KEY[2]; iv = TV_IV[2]; iv_len = TV_LEN[2]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 2000) begin
      if (cyc == 30) begin start = 1'b1; iv_len = 7'd3; end
      else start = 1'b0;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    check(cyc == 197, "R4 load length unchanged", 64'(cyc), 64'd197);
    consume(32, 0, got);
    exp = ref_ks(TV_KEY[2], TV_IV[2], 37, 32);
    check(got == exp, "R4 keystream unchanged", got, exp);

    // R9: stall holds bit and state
    run_load(TV_KEY[0], TV_IV[0], TV_LEN[0], cyc, sv);
    ks_ready = 1'b0;
    b0 = ks_bit;
    bad = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (!ks_valid || ks_bit !== b0) bad = 1'b1;
    end
    check(!bad, "R9 stall hold", 64'(bad), 64'd0);
    consume(32, 0, got);
    exp = ref_ks(TV_KEY[0], TV_IV[0], 0, 32);
    check(got == exp, "R9 no advance during stall", got, exp);

    // R8: usage limit with LIMIT_LOG = 6
    run_load(TV_KEY[3], TV_IV[3], TV_LEN[3], cyc, sv);
    consume(64, 0, got);
    exp = ref_ks(TV_KEY[3], TV_IV[3], 1, 64);
    check(got == exp, "R8 bits up to limit", got, exp);
    ks_ready = 1'b1;
    bad = ks_valid;
    repeat (3) begin
      @(negedge clk);
      if (ks_valid) bad = 1'b1;
    end
    ks_ready = 1'b0;
    check(!bad, "R8 valid low after limit", 64'(bad), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule